// File: doc/BRIEF.md
# Bias Supply Startup and Undervoltage Sequencer

This block decides when an off-line converter's own control supply is charged from the high-voltage input and when the power switch may run. It sees five digital inputs. Four are comparator flags: bulk voltage is high enough to start, the supply is above its turn-on level, the supply is above its regeneration level, and the supply is above its undervoltage-off level. The fifth is an indicator from the PWM that the power switch is in its off-time. From these inputs it drives an enable for one high-voltage charging source, a select between that source's low startup current and its higher operating current, a switching enable and a power-good flag.

The source is used in two phases. The first phase is an initial charge at low current, which starts once the bulk voltage is present. Later, while the converter switches, the source tops up the supply at the higher current. It does this only after the supply has sagged to the regeneration level, only until the supply climbs back to the turn-on level, and only while the switch is off. If an auxiliary winding holds the supply above the regeneration level, the source stays off in steady operation. Each comparator flag is passed through a two-flop synchronizer and then a glitch filter before the state machine uses it.

Top module: `bias_supply_sequencer`

## Requirements
- R1: After reset, and while the filtered bulk flag is low in the idle state, `hv_src_en`, `hv_src_hi`, `sw_enable` and `power_good` are all 0.
- R2: When the filtered bulk flag is high in the idle state, the block enters the startup charge: `hv_src_en`=1, `hv_src_hi`=0 (low current), `sw_enable`=0, `power_good`=0.
- R3: During the startup charge, a high turn-on flag enables switching and power-good and turns the charging source off (`hv_src_en`=0, `hv_src_hi`=0).
- R4: While running, a low regeneration flag selects the operating current (`hv_src_hi`=1). The block stays in this recharge phase, even after the regeneration flag returns high, until the turn-on flag is high. It then goes back to running with `hv_src_hi`=0.
- R5: While running with the regeneration flag held high, `hv_src_en` stays 0 whatever the off-time input does.
- R6: In the recharge phase, `hv_src_en` equals `sw_off_time` in the same cycle. Switching and power-good stay 1 throughout.
- R7: While switching, a low undervoltage flag drops `sw_enable` and `power_good` one clock after the filtered flag falls.
- R8: After an undervoltage event the block returns to the startup charge if the filtered bulk flag is high, and to idle otherwise.
- R9: Each comparator flag passes a two-flop synchronizer and a glitch filter. A level held for fewer than FILT_LEN (4) consecutive clocks is ignored.
- R10: If the filtered bulk flag falls during the startup charge, the block returns to idle with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bulk_ok_raw | input | 1 | Bulk voltage above start threshold (asynchronous) |
| vdd_on_raw | input | 1 | Supply above turn-on threshold (asynchronous) |
| vdd_regen_raw | input | 1 | Supply above regeneration threshold (asynchronous) |
| vdd_uv_ok_raw | input | 1 | Supply above undervoltage-off threshold (asynchronous) |
| sw_off_time | input | 1 | Power switch is in off-time (from the PWM, same clock domain) |
| hv_src_en | output | 1 | Enable the high-voltage charging source |
| hv_src_hi | output | 1 | 1 selects operating current, 0 the startup current |
| sw_enable | output | 1 | Switching allowed; 0 holds the gate low |
| power_good | output | 1 | Control supply is in regulation |

## Verification
The assertions check on every cycle that operating-current charging happens only during switch off-time. They also check that the low startup current never coincides with switching, that power-good and switching move together, that a lost undervoltage flag removes switching on the next clock, and that a filtered flag changes only after its synchronized input has agreed for the preceding cycles. The bench scenarios show the full sequence orderings: the hysteresis in the recharge phase, the auxiliary-winding case in which charging never starts, the return to startup or idle after undervoltage, and the rejection of short glitches. These can only be shown as sequences over many cycles.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int FLG_BULK  = 0;
    localparam int FLG_VON   = 1;
    localparam int FLG_REGEN = 2;
    localparam int FLG_UVOK  = 3;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_STARTUP_CHG = 3'd1,
        ST_RUN         = 3'd2,
        ST_RUN_RECHG   = 3'd3,
        ST_UVLO        = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic bulk_ok;
        logic vdd_on;
        logic vdd_regen;
        logic vdd_uv_ok;
    } flag_set_t;

    typedef struct packed {
        logic hv_en;
        logic hv_hi;
        logic sw_en;
        logic pgood;
    } seq_out_t;

    function automatic logic is_running(seq_state_e s);
        return (s == ST_RUN) || (s == ST_RUN_RECHG);
    endfunction

endpackage

// File: rtl/flag_conditioner.sv
module flag_conditioner #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic          sync1, sync2;
    logic          filt_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw_in;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q  <= 1'b0;
            run_cnt <= '0;
        end else if (sync2 == filt_q) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            filt_q  <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign clean_out = filt_q;

    // R9: a filtered change needs agreement from the synchronized input beforehand
    p_filter_agrees_r9: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> ($past(sync2) == filt_q && $past(sync2, 2) == filt_q))
        else $error("filter changed without stable input");

endmodule

// File: rtl/bias_seq_fsm.sv
module bias_seq_fsm
    import bias_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_set_t flags,
    input  logic      off_time,
    output seq_out_t  outs
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (flags.bulk_ok) state_d = ST_STARTUP_CHG;
            ST_STARTUP_CHG:
                if (!flags.bulk_ok)    state_d = ST_IDLE;
                else if (flags.vdd_on) state_d = ST_RUN;
            ST_RUN:
                if (!flags.vdd_uv_ok)      state_d = ST_UVLO;
                else if (!flags.vdd_regen) state_d = ST_RUN_RECHG;
            ST_RUN_RECHG:
                if (!flags.vdd_uv_ok)  state_d = ST_UVLO;
                else if (flags.vdd_on) state_d = ST_RUN;
            ST_UVLO:
                state_d = flags.bulk_ok ? ST_STARTUP_CHG : ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        outs       = '0;
        outs.sw_en = is_running(state_q);
        outs.pgood = is_running(state_q);
        case (state_q)
            ST_STARTUP_CHG: outs.hv_en = 1'b1;
            ST_RUN_RECHG: begin
                outs.hv_hi = 1'b1;
                outs.hv_en = off_time;
            end
            default: ;
        endcase
    end

    // R6: operating-current charging only while the switch is off
    p_hi_charge_offtime_r6: assert property (@(posedge clk) disable iff (rst)
        (outs.hv_en && outs.hv_hi) |-> off_time)
        else $error("operating charge during on-time");

    // R2: the startup current never coincides with switching
    p_lo_charge_no_switch_r2: assert property (@(posedge clk) disable iff (rst)
        (outs.hv_en && !outs.hv_hi) |-> !outs.sw_en)
        else $error("startup charge while switching");

    // R7: a lost undervoltage flag stops switching on the next clock
    p_uvlo_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (outs.sw_en && !flags.vdd_uv_ok) |=> (!outs.sw_en && !outs.pgood))
        else $error("switching continued after undervoltage");

    // R3: switching only begins from a turn-on condition during startup charge
    p_run_entry_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.sw_en) |-> $past(flags.vdd_on && flags.bulk_ok))
        else $error("switching started without turn-on flag");

    // R8: leaving switching through undervoltage lands in startup charge or idle
    p_uvlo_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UVLO) |=> (state_q == ST_STARTUP_CHG || state_q == ST_IDLE))
        else $error("bad exit from undervoltage");

endmodule

// File: rtl/bias_supply_sequencer.sv
module bias_supply_sequencer
    import bias_seq_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bulk_ok_raw,
    input  logic vdd_on_raw,
    input  logic vdd_regen_raw,
    input  logic vdd_uv_ok_raw,
    input  logic sw_off_time,
    output logic hv_src_en,
    output logic hv_src_hi,
    output logic sw_enable,
    output logic power_good
);
    logic [NUM_FLAGS-1:0] raw_vec;
    logic [NUM_FLAGS-1:0] clean_vec;
    flag_set_t            flags;
    seq_out_t             outs;

    assign raw_vec[FLG_BULK]  = bulk_ok_raw;
    assign raw_vec[FLG_VON]   = vdd_on_raw;
    assign raw_vec[FLG_REGEN] = vdd_regen_raw;
    assign raw_vec[FLG_UVOK]  = vdd_uv_ok_raw;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cond
        flag_conditioner #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (raw_vec[i]),
            .clean_out(clean_vec[i])
        );
    end

    assign flags.bulk_ok   = clean_vec[FLG_BULK];
    assign flags.vdd_on    = clean_vec[FLG_VON];
    assign flags.vdd_regen = clean_vec[FLG_REGEN];
    assign flags.vdd_uv_ok = clean_vec[FLG_UVOK];

    bias_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .off_time(sw_off_time),
        .outs    (outs)
    );

    assign hv_src_en  = outs.hv_en;
    assign hv_src_hi  = outs.hv_hi;
    assign sw_enable  = outs.sw_en;
    assign power_good = outs.pgood;

    // R1: power-good and switching enable always agree
    p_pgood_tracks_sw_r1: assert property (@(posedge clk) disable iff (rst)
        power_good == sw_enable)
        else $error("power_good and sw_enable disagree");

endmodule

// File: tb/bias_supply_sequencer_bench.sv
module bias_supply_sequencer_bench;
    logic clk = 1'b0;
    logic rst;
    logic bulk, von, regen, uvok, offt;
    logic hv_en, hv_hi, sw_en, pg;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #4 clk = ~clk;

    bias_supply_sequencer u_bias_supply_sequencer (
        .clk(clk), .rst(rst),
        .bulk_ok_raw(bulk), .vdd_on_raw(von), .vdd_regen_raw(regen),
        .vdd_uv_ok_raw(uvok), .sw_off_time(offt),
        .hv_src_en(hv_en), .hv_src_hi(hv_hi), .sw_enable(sw_en), .power_good(pg)
    );

    // inputs {bulk,von,regen,uvok,offt} then expected {hv_en,hv_hi,sw_en,pg}
    localparam int NV = 13;
    localparam logic [8:0] VEC [NV] = '{
        9'b00000_0000, // R1 idle
        9'b10000_1000, // R2 startup charge
        9'b10010_1000, // R2 still charging
        9'b10110_1000, // R2 still charging
        9'b11110_0011, // R3 run, source off
        9'b10111_0011, // R5 regen high: no charge in off-time
        9'b10011_1111, // R4 recharge, off-time
        9'b10010_0111, // R6 recharge, on-time: source off
        9'b10111_1111, // R4 hysteresis: stay in recharge
        9'b11111_0011, // R4 back to run at turn-on
        9'b10011_1111, // R4 recharge again
        9'b10001_1000, // R8 undervoltage with bulk -> startup
        9'b00000_0000  // R10 bulk lost in startup -> idle
    };

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {hv_en, hv_hi, sw_en, pg};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] v);
        {bulk, von, regen, uvok, offt} = v;
    endtask

    initial begin
        rst = 1'b1;
        apply(5'b0);
        wait_clk(3);
        rst = 1'b0;
        check("R1 reset", 4'b0000);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][8:4]);
            wait_clk(12);
            check($sformatf("vector %0d", k), VEC[k][3:0]);
        end

        // R9: a 3-clock glitch on bulk is ignored
        bulk = 1'b1; wait_clk(3); bulk = 1'b0;
        for (int i = 0; i < 10; i++) begin
            wait_clk(1);
            if (hv_en !== 1'b0) begin
                n_fail++;
                $display("FAIL R9 glitch: hv_en got %b expected 0", hv_en);
            end
        end
        n_run++;
        check("R9 after glitch", 4'b0000);

        // R9: a held level is accepted
        bulk = 1'b1; wait_clk(12);
        check("R9 held level", 4'b1000);

        // reach recharge, then R6 same-cycle following of off-time
        von = 1'b1; regen = 1'b1; uvok = 1'b1; wait_clk(12);
        check("R3 run", 4'b0011);
        von = 1'b0; regen = 1'b0; offt = 1'b0; wait_clk(12);
        check("R6 recharge on-time", 4'b0111);
        offt = 1'b1; #1;
        check("R6 same cycle rise", 4'b1111);
        offt = 1'b0; #1;
        check("R6 same cycle fall", 4'b0111);

        // R7 + R8: undervoltage with bulk gone goes to idle
        bulk = 1'b0; wait_clk(12);
        check("R7 bulk ignored while running", 4'b0111);
        uvok = 1'b0; wait_clk(12);
        check("R8 undervoltage to idle", 4'b0000);

        // R1: reset mid-run
        bulk = 1'b1; uvok = 1'b1; regen = 1'b1; wait_clk(12);
        von = 1'b1; wait_clk(12);
        check("R3 run again", 4'b0011);
        rst = 1'b1; wait_clk(2);
        check("R1 reset mid-run", 4'b0000);
        rst = 1'b0;
        apply(5'b0); wait_clk(12);
        check("R1 idle after reset", 4'b0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule